// File: doc/BRIEF.md
# Packed Integer SIMD ALU

This block is a 64-bit packed integer execution unit. It treats the two operands, called the destination and the source, as eight unsigned byte lanes or four 16-bit word lanes. It applies one operation to every lane pair at once. The operations are a rounding average, signed word minimum and maximum, unsigned byte minimum and maximum, and an unsigned word multiply that keeps the upper half of each product. A horizontal sum of absolute byte differences folds all eight byte lanes into one scalar.

An operation is presented with a 4-bit code and a valid strobe. The result is registered and appears, tagged valid, on the next clock. Codes that name no operation return the destination operand unchanged. Byte lane i occupies bits [8i+7:8i] and word lane j occupies bits [16j+15:16j] of every operand and of the result, so each lane of the result lines up with the lanes it came from.

Top module: `pk_simd_alu`

## Requirements
- R1: Opcode 0 (byte average) gives, in each byte lane, (d+s+1)>>1 computed on 9 bits with both lanes unsigned, so the average rounds up.
- R2: Opcode 1 (word average) gives, in each 16-bit lane, (d+s+1)>>1 computed on 17 bits with both lanes unsigned.
- R3: Opcode 2 gives the smaller and opcode 3 the larger of each pair of 16-bit lanes, both compared as two's-complement signed values.
- R4: Opcode 4 gives the smaller and opcode 5 the larger of each pair of byte lanes, both compared as unsigned values.
- R5: Opcode 6 multiplies each pair of 16-bit lanes as unsigned values and returns bits [31:16] of the 32-bit product in that lane.
- R6: Opcode 7 adds the absolute differences |d-s| of all eight unsigned byte pairs. The sum goes in result bits [15:0], and bits [63:16] are zero.
- R7: Opcodes 8 to 15 return the destination operand unchanged.
- R8: out_valid is high in the cycle after in_valid is sampled high and low otherwise. The result register loads only when in_valid is sampled high and holds its value when in_valid is low.
- R9: While rst_n is low, out_valid and out_result are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation present this cycle |
| in_op | input | 4 | Operation code |
| in_dst | input | 64 | Destination operand (first operand) |
| in_src | input | 64 | Source operand (second operand) |
| out_valid | output | 1 | Result valid |
| out_result | output | 64 | Registered packed result |

## Verification
The assertions assume that in_valid, in_op and both operands carry known values at every rising edge after reset. They also assume that in_valid stays low while reset is applied. The bench drives all inputs on the falling edge and holds in_valid low throughout reset, so these assumptions hold. It then sweeps all sixteen opcodes with corner operands (all zero, all ones, sign boundaries, mixed patterns) and with many pseudo-random operands. It inserts idle cycles with changed operands to show that the held result does not move.

// File: rtl/pk_simd_alu.sv
module pk_simd_alu #(
  parameter int DW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [3:0]    in_op,
  input  logic [DW-1:0] in_dst,
  input  logic [DW-1:0] in_src,
  output logic          out_valid,
  output logic [DW-1:0] out_result
);
  localparam int NB   = DW / 8;
  localparam int NW   = DW / 16;
  localparam int SADW = $clog2(NB * 255 + 1);

  localparam logic [3:0] OP_AVGB = 4'd0;
  localparam logic [3:0] OP_AVGW = 4'd1;
  localparam logic [3:0] OP_MINW = 4'd2;
  localparam logic [3:0] OP_MAXW = 4'd3;
  localparam logic [3:0] OP_MINB = 4'd4;
  localparam logic [3:0] OP_MAXB = 4'd5;
  localparam logic [3:0] OP_MULH = 4'd6;
  localparam logic [3:0] OP_SAD  = 4'd7;

  logic [DW-1:0] avg_b, avg_w, min_w, max_w, min_b, max_b, mul_h, nxt;
  logic [7:0]    absd [NB];
  logic [SADW-1:0] sad;

  for (genvar i = 0; i < NB; i++) begin : g_byte
    logic [7:0] a, b;
    logic [8:0] s;
    assign a = in_dst[8*i +: 8];
    assign b = in_src[8*i +: 8];
    assign s = {1'b0, a} + {1'b0, b} + 9'd1;
    assign avg_b[8*i +: 8] = s[8:1];
    assign min_b[8*i +: 8] = (a < b) ? a : b;
    assign max_b[8*i +: 8] = (a < b) ? b : a;
    assign absd[i] = (a > b) ? (a - b) : (b - a);
  end

  for (genvar j = 0; j < NW; j++) begin : g_word
    logic [15:0] a, b;
    logic [16:0] s;
    logic [31:0] p;
    assign a = in_dst[16*j +: 16];
    assign b = in_src[16*j +: 16];
    assign s = {1'b0, a} + {1'b0, b} + 17'd1;
    assign p = {16'd0, a} * {16'd0, b};
    assign avg_w[16*j +: 16] = s[16:1];
    assign min_w[16*j +: 16] = ($signed(a) < $signed(b)) ? a : b;
    assign max_w[16*j +: 16] = ($signed(a) < $signed(b)) ? b : a;
    assign mul_h[16*j +: 16] = p[31:16];
  end

  always_comb begin
    sad = '0;
    for (int k = 0; k < NB; k++)
      sad = sad + {{(SADW-8){1'b0}}, absd[k]};
  end

  always_comb begin
    case (in_op)
      OP_AVGB: nxt = avg_b;
      OP_AVGW: nxt = avg_w;
      OP_MINW: nxt = min_w;
      OP_MAXW: nxt = max_w;
      OP_MINB: nxt = min_b;
      OP_MAXB: nxt = max_b;
      OP_MULH: nxt = mul_h;
      OP_SAD:  nxt = {{(DW-SADW){1'b0}}, sad};
      default: nxt = in_dst;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_result <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_result <= nxt;
    end
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n) in_valid |=> out_valid); // R8
  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> !out_valid); // R8
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> $stable(out_result)); // R8
  AST_SAD_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && in_op == OP_SAD) |=> out_result[DW-1:16] == '0); // R6
  AST_UNKNOWN_PASS: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && in_op[3]) |=> out_result == $past(in_dst)); // R7
  AST_RESET_CLEAR: assert property (@(posedge clk) !rst_n |-> (!out_valid && out_result == '0)); // R9
endmodule

// File: tb/pk_simd_alu_tb.sv
`timescale 1ns/1ps
module pk_simd_alu_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [3:0]  in_op = '0;
  logic [63:0] in_dst = '0, in_src = '0;
  logic        out_valid;
  logic [63:0] out_result;

  int checks = 0, errors = 0;
  bit done = 0;

  pk_simd_alu u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
    .in_dst(in_dst), .in_src(in_src), .out_valid(out_valid), .out_result(out_result)
  );

  always #4 clk = ~clk;

  function automatic logic [63:0] model(input logic [3:0] op, input logic [63:0] d, input logic [63:0] s);
    logic [63:0] r;
    int unsigned acc;
    r = d;
    acc = 0;
    for (int i = 0; i < 8; i++) begin
      int unsigned a, b;
      a = d[8*i +: 8]; b = s[8*i +: 8];
      case (op)
        4'd0: r[8*i +: 8] = 8'((a + b + 1) / 2);
        4'd4: r[8*i +: 8] = 8'((a < b) ? a : b);
        4'd5: r[8*i +: 8] = 8'((a > b) ? a : b);
        default: ;
      endcase
      acc += (a > b) ? a - b : b - a;
    end
    for (int j = 0; j < 4; j++) begin
      int unsigned a, b;
      int sa, sb;
      longint unsigned p;
      a = d[16*j +: 16]; b = s[16*j +: 16];
      sa = int'($signed(d[16*j +: 16])); sb = int'($signed(s[16*j +: 16]));
      p = longint'(a) * longint'(b);
      case (op)
        4'd1: r[16*j +: 16] = 16'((a + b + 1) / 2);
        4'd2: r[16*j +: 16] = (sa < sb) ? d[16*j +: 16] : s[16*j +: 16];
        4'd3: r[16*j +: 16] = (sa > sb) ? d[16*j +: 16] : s[16*j +: 16];
        4'd6: r[16*j +: 16] = 16'(p / 65536);
        default: ;
      endcase
    end
    if (op == 4'd7) r = {48'd0, 16'(acc)};
    return r;
  endfunction

  function automatic string tag(input logic [3:0] op);
    case (op)
      4'd0: return "R1";
      4'd1: return "R2";
      4'd2, 4'd3: return "R3";
      4'd4, 4'd5: return "R4";
      4'd6: return "R5";
      4'd7: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [3:0] op, input logic [63:0] d, input logic [63:0] s);
    in_valid = 1'b1; in_op = op; in_dst = d; in_src = s;
    @(negedge clk);
    check("R8 valid", {63'd0, out_valid}, 64'd1);
    check(tag(op), out_result, model(op, d, s));
  endtask

  task automatic idle();
    logic [63:0] prev;
    prev = out_result;
    in_valid = 1'b0; in_op = 4'($urandom); in_dst = {$urandom, $urandom}; in_src = {$urandom, $urandom};
    @(negedge clk);
    check("R8 idle valid", {63'd0, out_valid}, 64'd0);
    check("R8 hold", out_result, prev);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [63:0] corner [6];
    corner[0] = 64'h0;
    corner[1] = 64'hFFFF_FFFF_FFFF_FFFF;
    corner[2] = 64'h8000_8000_8000_8000;
    corner[3] = 64'h7FFF_7FFF_7FFF_7FFF;
    corner[4] = 64'hA55A_A55A_AAFF_AAFF;
    corner[5] = 64'h0001_FF80_7F01_00FE;
    repeat (3) @(negedge clk);
    check("R9 valid", {63'd0, out_valid}, 64'd0);
    check("R9 result", out_result, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int op = 0; op < 16; op++)
      for (int x = 0; x < 6; x++)
        for (int y = 0; y < 6; y++)
          apply(4'(op), corner[x], corner[y]);
    apply(4'd2, 64'hA55A_A55A_A55A_A55A, 64'hAAFF_AAFF_AAFF_AAFF);
    check("R3 signed min", out_result, 64'hA55A_A55A_A55A_A55A);
    apply(4'd7, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0);
    check("R6 sad max", out_result, 64'd2040);
    for (int op = 0; op < 16; op++)
      for (int n = 0; n < 600; n++) begin
        apply(4'(op), {$urandom, $urandom}, {$urandom, $urandom});
        if (n % 50 == 0) idle();
      end
    for (int a = 0; a < 256; a += 3)
      apply(4'(a % 8), {8{8'(a)}}, {8'(a+1), 8'(a+2), 8'(255-a), 8'(a), 8'(a^8'h80), 8'(a*3), 8'd0, 8'hFF});
    idle();
    idle();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule